// File: doc/BRIEF.md
# Buffered Four-Channel Timer Compare Unit

This block sits next to a 10-bit timer counter and compares the live count, every cycle and in parallel, against four 10-bit compare values (channels A, B, C and D). Each equality gives a match indication for that channel to a downstream waveform generator. A per-channel force strobe can also produce such a match pulse. The unit also passes the counter's top and bottom strobes through to the waveform generator. For channels A, B and D, a match sets a sticky flag one timer clock later. A set flag whose enable is on raises an interrupt request. The flag is cleared either when that interrupt is acknowledged or when software writes a one to the flag's bit.

A processor loads the compare values over an 8-bit write bus. The two upper bits of a value go first into a shared holding register. Writing the low byte of a channel then transfers the whole 10-bit value in one step. In normal mode the transfer updates the active compare value at once. In PWM mode it only fills a per-channel buffer. The buffer is copied into the active compare value when the counter reaches its top strobe, or its bottom strobe if the commit-select input asks for bottom. Compare values therefore never change in the middle of a period.

Top module: `tcmp_unit`

## Requirements
- R1: `match_o[k]` is 1 in the same cycle in which `cnt_i` equals channel k's active compare value (bit 0 = A, 1 = B, 2 = C, 3 = D).
- R2: A flag bit is set at the clock edge that ends a cycle in which its channel's equality holds, so it becomes visible one cycle later. Flag bit 0 = A, bit 1 = B, bit 2 = D. Channel C has no flag.
- R3: `irq_o[f]` equals `flag_o[f]` AND the interrupt enable bit f. The enables are written at address 6 from `wr_data_i[2:0]`.
- R4: `irq_ack_i[f]` clears flag f at the next edge, unless an equality sets it again in that same cycle (setting wins).
- R5: A write to address 5 clears each flag whose data bit (bits 2:0) is 1. Flags whose data bit is 0 keep their value.
- R6: A write to address 4 stores `wr_data_i[1:0]` as the shared upper bits. A write to address 0, 1, 2 or 3 (channel A, B, C, D) transfers {upper bits, `wr_data_i`} as a 10-bit value. The upper bits are kept for later writes.
- R7: With `pwm_mode_i` = 0, a transferred value becomes the active compare value at the next edge.
- R8: With `pwm_mode_i` = 1, a transferred value goes only to the channel buffer. Buffers are copied to the active values on `top_stb_i` when `commit_bot_i` = 0, and on `bot_stb_i` when it is 1. The other strobe has no effect.
- R9: When a transfer and a commit fall in the same cycle, the active value takes the buffer content from before that transfer, and the buffer takes the new value.
- R10: `force_i[k]` makes `match_o[k]` 1 in that cycle without setting any flag.
- R11: `top_o` and `bot_o` follow `top_stb_i` and `bot_stb_i` in the same cycle.
- R12: After reset, all active values, buffers and upper bits are 0, and all flags and enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 10 | Current counter value |
| top_stb_i | input | 1 | One-cycle strobe: counter at top |
| bot_stb_i | input | 1 | One-cycle strobe: counter at bottom |
| pwm_mode_i | input | 1 | 1 = buffered (PWM) writes, 0 = direct writes |
| commit_bot_i | input | 1 | 1 = commit buffers at bottom, 0 = at top |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 3 | Write address (0-3 low bytes, 4 upper bits, 5 flag clear, 6 enables) |
| wr_data_i | input | 8 | Write data |
| force_i | input | 4 | Per-channel forced match strobe |
| irq_ack_i | input | 3 | Interrupt serviced, per flag |
| match_o | output | 4 | Per-channel match to waveform generator |
| top_o | output | 1 | Top indication to waveform generator |
| bot_o | output | 1 | Bottom indication to waveform generator |
| flag_o | output | 3 | Compare flags for A, B, D |
| irq_o | output | 3 | Interrupt requests for A, B, D |

## Verification
The bench targets the commit boundary. A design that commits on the wrong strobe, or that lets a PWM-mode write reach the active value early, shows a match in a period where none is due. It also checks a write that lands on the same cycle as a commit: a design that forwards the new value would match one period too soon. It checks that the upper bits are kept across low-byte writes, that the flag is set one cycle late and that a set wins over a clear in the same cycle, and that forced matches and channel C never touch a flag. A design that set flags in the same cycle, lost a set when a clear arrived with it, or mapped channel C onto a flag bit would show a mismatch on `flag_o` or `irq_o`.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
    localparam int CMP_W  = 10;
    localparam int BUS_W  = 8;
    localparam int NCH    = 4;
    localparam int NFLG   = 3;
    localparam int HI_W   = CMP_W - BUS_W;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        AD_LO_A = 3'd0,
        AD_LO_B = 3'd1,
        AD_LO_C = 3'd2,
        AD_LO_D = 3'd3,
        AD_HI   = 3'd4,
        AD_FCLR = 3'd5,
        AD_IEN  = 3'd6,
        AD_RSVD = 3'd7
    } addr_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  data;
    } bus_req_t;

    // flag index -> channel index; channel C (2) carries no flag
    function automatic int flag_chan(input int f);
        return (f >= 2) ? f + 1 : f;
    endfunction
endpackage

// File: rtl/tcmp_channel.sv
module tcmp_channel
    import tcmp_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMP_W-1:0] cnt_i,
    input  bus_req_t         req_i,
    input  logic [HI_W-1:0]  hold_i,
    input  logic             pwm_i,
    input  logic             commit_i,
    input  logic             force_i,
    output logic             eq_o,
    output logic             match_o
);
    logic [CMP_W-1:0] act_q, buf_q, wr_val;
    logic             wr_me;

    assign wr_me  = req_i.wr && (req_i.addr == ADDR_W'(IDX));
    assign wr_val = {hold_i, req_i.data};

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            buf_q <= '0;
        end else begin
            if (commit_i)
                act_q <= buf_q;
            if (wr_me) begin
                buf_q <= wr_val;
                if (!pwm_i)
                    act_q <= wr_val;
            end
        end
    end

    assign eq_o    = (cnt_i == act_q);
    assign match_o = eq_o | force_i;

    // R8: buffered mode leaves the active value alone between commits
    a_r8_hold_until_commit: assert property (@(posedge clk) disable iff (rst)
        (pwm_i && !commit_i) |=> $stable(act_q));
    // R7: direct mode writes land at the next edge
    a_r7_direct_write: assert property (@(posedge clk) disable iff (rst)
        (!pwm_i && wr_me) |=> (act_q == $past(wr_val)));
    // R9: a commit coinciding with a write uses the older buffer
    a_r9_commit_old_buf: assert property (@(posedge clk) disable iff (rst)
        (commit_i && wr_me) |=> (act_q == $past(buf_q)));
endmodule

// File: rtl/tcmp_flags.sv
module tcmp_flags
    import tcmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NFLG-1:0] set_i,
    input  logic [NFLG-1:0] swclr_i,
    input  logic [NFLG-1:0] ack_i,
    input  logic            en_wr_i,
    input  logic [NFLG-1:0] en_data_i,
    output logic [NFLG-1:0] flag_o,
    output logic [NFLG-1:0] irq_o
);
    logic [NFLG-1:0] flag_q, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~(swclr_i | ack_i)) | set_i;
            if (en_wr_i)
                en_q <= en_data_i;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_q;

    for (genvar f = 0; f < NFLG; f++) begin : g_chk
        // R2: equality sets the flag one edge later
        a_r2_set_next: assert property (@(posedge clk) disable iff (rst)
            set_i[f] |=> flag_q[f]);
        // R3: a request needs a flag
        a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
            irq_o[f] |-> flag_q[f]);
        // R4: acknowledge clears when no new set arrives
        a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (ack_i[f] && !set_i[f]) |=> !flag_q[f]);
        // R5: without a clear the flag is sticky
        a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
            (flag_q[f] && !swclr_i[f] && !ack_i[f]) |=> flag_q[f]);
    end
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CMP_W-1:0]  cnt_i,
    input  logic              top_stb_i,
    input  logic              bot_stb_i,
    input  logic              pwm_mode_i,
    input  logic              commit_bot_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BUS_W-1:0]  wr_data_i,
    input  logic [NCH-1:0]    force_i,
    input  logic [NFLG-1:0]   irq_ack_i,
    output logic [NCH-1:0]    match_o,
    output logic              top_o,
    output logic              bot_o,
    output logic [NFLG-1:0]   flag_o,
    output logic [NFLG-1:0]   irq_o
);
    bus_req_t        req;
    logic [HI_W-1:0] hold_q;
    logic            commit;
    logic [NCH-1:0]  eq;
    logic [NFLG-1:0] flag_set, swclr;

    assign req = '{wr: wr_en_i, addr: wr_addr_i, data: wr_data_i};

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (req.wr && req.addr == AD_HI)
            hold_q <= req.data[HI_W-1:0];
    end

    assign commit = pwm_mode_i && (commit_bot_i ? bot_stb_i : top_stb_i);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        tcmp_channel #(.IDX(k)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cnt_i    (cnt_i),
            .req_i    (req),
            .hold_i   (hold_q),
            .pwm_i    (pwm_mode_i),
            .commit_i (commit),
            .force_i  (force_i[k]),
            .eq_o     (eq[k]),
            .match_o  (match_o[k])
        );
    end

    for (genvar f = 0; f < NFLG; f++) begin : g_map
        assign flag_set[f] = eq[flag_chan(f)];
    end

    assign swclr = (req.wr && req.addr == AD_FCLR) ? req.data[NFLG-1:0] : '0;

    tcmp_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_i     (flag_set),
        .swclr_i   (swclr),
        .ack_i     (irq_ack_i),
        .en_wr_i   (req.wr && req.addr == AD_IEN),
        .en_data_i (req.data[NFLG-1:0]),
        .flag_o    (flag_o),
        .irq_o     (irq_o)
    );

    assign top_o = top_stb_i;
    assign bot_o = bot_stb_i;

    // R10: a flag only rises after a real equality, never after a force alone
    a_r10_force_no_flag: assert property (@(posedge clk) disable iff (rst)
        (!flag_o[0] && !eq[0]) |=> !flag_o[0]);
    // R1: equality always reaches the match output
    a_r1_eq_matches: assert property (@(posedge clk) disable iff (rst)
        (cnt_i == cnt_i) |-> ((eq & ~match_o) == '0));
endmodule

// File: tb/tb_tcmp_unit.sv
`timescale 1ns/1ps
module tb_tcmp_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] cnt = 10'h3F0;
    logic       top = 0, bot = 0, pwm = 0, csel = 0, wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [3:0] frc = 0;
    logic [2:0] ack = 0;
    logic [3:0] match;
    logic       top_o, bot_o;
    logic [2:0] flag, irq;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [9:0] m_act [4];
    logic [9:0] m_buf [4];
    logic [1:0] m_hold;
    logic [2:0] m_flag, m_en;

    always #2 clk = ~clk;

    tcmp_unit dut (
        .clk(clk), .rst(rst), .cnt_i(cnt), .top_stb_i(top), .bot_stb_i(bot),
        .pwm_mode_i(pwm), .commit_bot_i(csel), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .force_i(frc),
        .irq_ack_i(ack), .match_o(match), .top_o(top_o), .bot_o(bot_o),
        .flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin m_act[k] = 0; m_buf[k] = 0; end
        m_hold = 0; m_flag = 0; m_en = 0;
    endtask

    function automatic logic [3:0] exp_eq();
        logic [3:0] e;
        for (int k = 0; k < 4; k++) e[k] = (cnt == m_act[k]);
        return e;
    endfunction

    task automatic model_tick();
        logic [3:0] e;
        logic [9:0] v;
        logic [2:0] clr;
        logic       cm;
        e  = exp_eq();
        cm = pwm && (csel ? bot : top);
        v  = {m_hold, wr_data};
        for (int k = 0; k < 4; k++) begin
            if (cm) m_act[k] = m_buf[k];
            if (wr_en && wr_addr == 3'(k)) begin
                m_buf[k] = v;
                if (!pwm) m_act[k] = v;
            end
        end
        if (wr_en && wr_addr == 3'd4) m_hold = wr_data[1:0];
        clr = ((wr_en && wr_addr == 3'd5) ? wr_data[2:0] : 3'b000) | ack;
        m_flag = (m_flag & ~clr) | {e[3], e[1], e[0]};
        if (wr_en && wr_addr == 3'd6) m_en = wr_data[2:0];
    endtask

    // inputs are applied; check outputs, clock once, update model, clear pulses
    task automatic step();
        #1;
        chk("R1/R10 match", 10'(match), 10'(exp_eq() | frc));
        chk("R2 flag", 10'(flag), 10'(m_flag));
        chk("R3 irq", 10'(irq), 10'(m_flag & m_en));
        chk("R11 top/bot", 10'({top_o, bot_o}), 10'({top, bot}));
        @(posedge clk);
        model_tick();
        @(negedge clk);
        wr_en = 0; top = 0; bot = 0; frc = 0; ack = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        rst = 1;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 0;

        // R12 reset state
        #1;
        chk("R12 flags", 10'(flag), 10'h0);
        chk("R12 irq", 10'(irq), 10'h0);
        chk("R12 no match idle", 10'(match), 10'h0);
        cnt = 10'h000; #0.5;
        chk("R12 compare values zero", 10'(match), 10'hF);
        cnt = 10'h3F0;
        @(negedge clk);

        // R6 upper bits + low byte; R7 immediate in normal mode
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h34);
        cnt = 10'h234; #0.5;
        chk("R6 full value A", 10'(match), 10'h1);
        wr(3'd1, 8'h11);
        chk("R2 flag one cycle after equality", 10'(flag), 10'h1);
        cnt = 10'h211; #0.5;
        chk("R6 upper bits kept for B", 10'(match), 10'h2);
        cnt = 10'h3F0;
        step();

        // R2 channel C has no flag
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h07);
        wr(3'd2, 8'h99);
        cnt = 10'h199;
        step();
        cnt = 10'h3F0;
        step();
        chk("R2 channel C sets nothing", 10'(flag), 10'h0);

        // R5 write-one-to-clear
        cnt = 10'h234; step(); cnt = 10'h3F0; step();
        wr(3'd5, 8'h00);
        chk("R5 zero keeps flag", 10'(flag), 10'h1);
        wr(3'd5, 8'h01);
        chk("R5 one clears flag", 10'(flag), 10'h0);

        // R3 enable, R4 acknowledge
        wr(3'd6, 8'h01);
        cnt = 10'h234; step(); cnt = 10'h3F0; #0.5;
        chk("R3 irq with enable", 10'(irq), 10'h1);
        ack = 3'b001; step();
        chk("R4 ack clears", 10'(flag), 10'h0);
        cnt = 10'h234; ack = 3'b001; step(); cnt = 10'h3F0;
        chk("R4 set wins over ack", 10'(flag), 10'h1);
        wr(3'd5, 8'h07);

        // R10 force on D
        frc = 4'b1000; #0.5;
        chk("R10 forced match", 10'(match), 10'h8);
        step();
        chk("R10 no flag from force", 10'(flag), 10'h0);

        // R8 PWM buffering, commit at top
        pwm = 1; csel = 0;
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h50);
        cnt = 10'h050; #0.5;
        chk("R8 buffered not active", 10'(match[0]), 10'h0);
        bot = 1; step();
        chk("R8 bottom ignored in top mode", 10'(match[0]), 10'h0);
        top = 1; step();
        chk("R8 committed at top", 10'(match[0]), 10'h1);
        cnt = 10'h3F0;
        // commit at bottom
        csel = 1;
        wr(3'd1, 8'h60);
        cnt = 10'h060;
        top = 1; step();
        chk("R8 top ignored in bottom mode", 10'(match[1]), 10'h0);
        bot = 1; step();
        chk("R8 committed at bottom", 10'(match[1]), 10'h1);
        cnt = 10'h3F0;

        // R9 write and commit in the same cycle
        csel = 0;
        wr(3'd0, 8'h80);
        top = 1; wr(3'd0, 8'h90);
        cnt = 10'h080; #0.5;
        chk("R9 old buffer committed", 10'(match[0]), 10'h1);
        top = 1; step();
        cnt = 10'h090; #0.5;
        chk("R9 new value next commit", 10'(match[0]), 10'h1);

        // R7 back to direct
        pwm = 0;
        wr(3'd3, 8'h22);
        cnt = 10'h022; #0.5;
        chk("R7 direct update", 10'(match[3]), 10'h1);
        wr(3'd5, 8'h07);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            cnt = 10'($urandom_range(0, 7)) | (($urandom % 2 == 0) ? 10'h000 : 10'h100);
            if ($urandom % 50 == 0) pwm = ~pwm;
            if ($urandom % 30 == 0) csel = ~csel;
            top = ($urandom % 8 == 0);
            bot = ($urandom % 8 == 0);
            frc = ($urandom % 16 == 0) ? 4'($urandom) : 4'h0;
            ack = ($urandom % 6 == 0) ? 3'($urandom) : 3'h0;
            wr_en = ($urandom % 3 == 0);
            wr_addr = 3'($urandom);
            wr_data = (wr_addr == 3'd4) ? 8'($urandom % 2) : 8'($urandom % 8);
            if (wr_addr >= 3'd5) wr_data = 8'($urandom);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule